// File: doc/BRIEF.md
# Second-Aligned Square-Wave Output Generator

This block keeps a free-running time value and drives a square wave from it onto an output pin. Time is held as two words. The low word counts clock cycles inside one second and wraps at a parameterised limit, which is one billion by default. The high word counts the completed seconds. Software writes a half-period, a two-word start time and a control word through a small write-only register port. The output stays low until the time value reaches the start time. It then rises and toggles once every half-period, so a one-pulse-per-second wave has its first rising edge on a whole second.

Two configuration registers decide whether the wave reaches the pin. The pin register holds the output-direction bit and the bit that selects the timing function for the pin. The routing register holds the enable and the source field. Each edge of the wave can raise a one-cycle interrupt pulse. Any write to the control word restarts the sequence, so writing zero stops the output at once.

Register addresses on `wr_addr`: 0 control, 1 half-period, 2 start low word, 3 start high word, 4 pin configuration, 5 routing.

Top module: `ckgen_clkout`

## Requirements
- R1: `time_lo` counts up by one each cycle, stays below LIMIT, and goes from LIMIT-1 to 0 in the same cycle that `time_hi` increments. Both words are 0 during reset.
- R2: For an armed start time S in the future, the first rising edge of `pin_out` appears in the cycle where the linear time (`time_hi`*LIMIT + `time_lo`) reads S+1. The comparison uses both words as one 64-bit value, including a start time of exactly a whole second.
- R3: If the start time is already past when the control write arms the block, the wave rises in the second cycle after that write: low in the cycle after the write, high in the next.
- R4: Writing 0 to the control word (address 0) forces the wave low from the next cycle on. It also clears any pending start, so no further edge or interrupt follows.
- R5: Arming needs control bits 0 (output enable), 1 (start arm) and 2 (start-as-source) all set in the same write. With any of them clear, no edge occurs.
- R6: After the first rise, the wave changes level every HALF cycles, where HALF is the half-period register (address 1). A HALF of 0 behaves as 1.
- R7: `pin_oe` equals pin-configuration bit 0 (direction). `pin_out` carries the wave only when all of these hold: pin bit 0 set, pin bit 1 (timing function) set, routing bit 0 (enable) set, and routing bits 2:1 (source) equal to 0. Otherwise `pin_out` is 0.
- R8: When control bit 3 is set, `irq` is high for exactly the cycle in which each new wave level first appears. When bit 3 is clear, `irq` stays low.
- R9: Control bit 4 (keep captured stamps) is presented on `stamp_hold` from the cycle after the write.
- R10: After reset, `pin_out`, `pin_oe`, `irq` and `stamp_hold` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| time_lo | output | 32 | Sub-second cycle count |
| time_hi | output | 32 | Whole-second count |
| pin_out | output | 1 | Gated square-wave output |
| pin_oe | output | 1 | Pin output enable (direction) |
| irq | output | 1 | One-cycle pulse on each wave edge |
| stamp_hold | output | 1 | Keep-captured-stamps control bit |

## Verification
Two functions can act in the same cycle: the rollover of the sub-second word and the start-time match. To provoke this, the bench programs a start time whose low word is zero and whose high word is the next second but one. The match then happens on the first value after the rollover. The bench judges the result by the linear time read at the rising edge, which must be the start plus one. A low-word-only or carry-late comparator would produce an early or late rise. A second overlap, a control write in a cycle where a toggle is due, is judged by the wave being low and silent afterwards.

// File: rtl/ckgen_pkg.sv
package ckgen_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_HALF   = 3'd1;
  localparam logic [ADDR_W-1:0] A_ST_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ST_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PIN    = 3'd4;
  localparam logic [ADDR_W-1:0] A_ROUTE  = 3'd5;

  // control word layout, bit 0 at the right
  typedef struct packed {
    logic stamp_hold;
    logic irq_en;
    logic src_sel;
    logic arm;
    logic out_en;
  } ctrl_t;

  // two-word time, upper word first, compared as one unsigned value
  function automatic logic time_reached(input logic [63:0] now_t,
                                        input logic [63:0] start_t);
    return now_t >= start_t;
  endfunction

  function automatic logic arm_request(input ctrl_t c);
    return c.out_en & c.arm & c.src_sel;
  endfunction

endpackage

// File: rtl/ckgen_timebase.sv
module ckgen_timebase #(
  parameter int LIMIT = 1000000000,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] t_lo,
  output logic [W-1:0] t_hi
);
  localparam logic [W-1:0] LO_LAST = W'(LIMIT - 1);

  logic wrap_evt;
  assign wrap_evt = (t_lo == LO_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_lo <= '0;
      t_hi <= '0;
    end else if (wrap_evt) begin
      t_lo <= '0;
      t_hi <= t_hi + 1'b1;
    end else begin
      t_lo <= t_lo + 1'b1;
    end
  end

  p_lo_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    t_lo <= LO_LAST);

  p_wrap_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (t_lo == '0 && t_hi == $past(t_hi) + 1'b1));

  p_hi_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(t_hi));

endmodule

// File: rtl/ckgen_trigger.sv
module ckgen_trigger #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm_load,
  input  logic         arm_value,
  input  logic [W-1:0] cur_lo,
  input  logic [W-1:0] cur_hi,
  input  logic [W-1:0] st_lo,
  input  logic [W-1:0] st_hi,
  output logic         fire
);
  import ckgen_pkg::*;

  logic armed;
  logic reached;

  assign reached = time_reached(64'({cur_hi, cur_lo}), 64'({st_hi, st_lo}));
  assign fire    = armed & reached & ~arm_load;

  always_ff @(posedge clk) begin
    if (!rst_n)        armed <= 1'b0;
    else if (arm_load) armed <= arm_value;
    else if (fire)     armed <= 1'b0;
  end

  p_disarm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed);

  p_no_fire_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_load && !arm_value) |=> !fire);

endmodule

// File: rtl/ckgen_wave.sv
module ckgen_wave #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop,
  input  logic         fire,
  input  logic [W-1:0] half,
  output logic         level,
  output logic         edge_evt
);
  logic         running;
  logic [W-1:0] cnt;
  logic         due;

  // countdown start value: a half-period of zero acts as one cycle
  function automatic logic [W-1:0] reload_of(input logic [W-1:0] h);
    return (h == '0) ? '0 : h - 1'b1;
  endfunction

  assign due      = running & (cnt == '0);
  assign edge_evt = ~stop & (fire | due);

  always_ff @(posedge clk) begin
    if (!rst_n || stop) begin
      running <= 1'b0;
      level   <= 1'b0;
      cnt     <= '0;
    end else if (fire) begin
      running <= 1'b1;
      level   <= 1'b1;
      cnt     <= reload_of(half);
    end else if (running) begin
      if (due) begin
        level <= ~level;
        cnt   <= reload_of(half);
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !stop && !fire) |=> (level != $past(level)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !due && !stop && !fire) |=> $stable(level));

  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !level);

endmodule

// File: rtl/ckgen_clkout.sv
module ckgen_clkout #(
  parameter int LIMIT = 1000000000,
  parameter int W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ckgen_pkg::ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]                wr_data,
  output logic [W-1:0]                time_lo,
  output logic [W-1:0]                time_hi,
  output logic                        pin_out,
  output logic                        pin_oe,
  output logic                        irq,
  output logic                        stamp_hold
);
  import ckgen_pkg::*;

  localparam int CW = $bits(ctrl_t);

  ctrl_t        wctl;
  logic         ctrl_wr;
  logic         irq_en_q;
  logic         hold_q;
  logic [W-1:0] half_q;
  logic [W-1:0] st_lo_q;
  logic [W-1:0] st_hi_q;
  logic         pin_dir_q;
  logic         pin_fn_q;
  logic         route_en_q;
  logic [1:0]   route_src_q;
  logic         fire;
  logic         level;
  logic         edge_evt;
  logic         irq_q;
  logic         route_ok;

  assign wctl    = ctrl_t'(wr_data[CW-1:0]);
  assign ctrl_wr = wr_en & (wr_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en_q    <= 1'b0;
      hold_q      <= 1'b0;
      half_q      <= '0;
      st_lo_q     <= '0;
      st_hi_q     <= '0;
      pin_dir_q   <= 1'b0;
      pin_fn_q    <= 1'b0;
      route_en_q  <= 1'b0;
      route_src_q <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL:  begin irq_en_q <= wctl.irq_en; hold_q <= wctl.stamp_hold; end
        A_HALF:  half_q  <= wr_data;
        A_ST_LO: st_lo_q <= wr_data;
        A_ST_HI: st_hi_q <= wr_data;
        A_PIN:   begin pin_dir_q <= wr_data[0]; pin_fn_q <= wr_data[1]; end
        A_ROUTE: begin route_en_q <= wr_data[0]; route_src_q <= wr_data[2:1]; end
        default: ;
      endcase
    end
  end

  ckgen_timebase #(.LIMIT(LIMIT), .W(W)) u_timebase (
    .clk  (clk),
    .rst_n(rst_n),
    .t_lo (time_lo),
    .t_hi (time_hi)
  );

  ckgen_trigger #(.W(W)) u_trigger (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_load (ctrl_wr),
    .arm_value(arm_request(wctl)),
    .cur_lo   (time_lo),
    .cur_hi   (time_hi),
    .st_lo    (st_lo_q),
    .st_hi    (st_hi_q),
    .fire     (fire)
  );

  ckgen_wave #(.W(W)) u_wave (
    .clk     (clk),
    .rst_n   (rst_n),
    .stop    (ctrl_wr),
    .fire    (fire),
    .half    (half_q),
    .level   (level),
    .edge_evt(edge_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= edge_evt & irq_en_q;
  end

  assign route_ok   = route_en_q & (route_src_q == 2'd0);
  assign pin_out    = level & pin_dir_q & pin_fn_q & route_ok;
  assign pin_oe     = pin_dir_q;
  assign irq        = irq_q;
  assign stamp_hold = hold_q;

  p_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data == '0) |=> (!pin_out && !irq));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en_q);

  p_irq_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (level != $past(level)));

  p_pin_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |-> (pin_dir_q && pin_fn_q && route_en_q && route_src_q == 2'd0));

endmodule

// File: tb/test_ckgen_clkout.sv
`timescale 1ns/1ps
module test_ckgen_clkout;
  localparam int LIM = 50;
  localparam int NV  = 5;
  localparam int T_HALF [NV] = '{4, 0, 7, 3, 5};
  localparam int T_DELTA[NV] = '{25, 20, 60, -5, 30};
  localparam int T_IRQ  [NV] = '{1, 1, 0, 1, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] time_lo, time_hi;
  logic        pin_out, pin_oe, irq, stamp_hold;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ckgen_clkout #(.LIMIT(LIM), .W(32)) i_ckgen_clkout (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .time_lo(time_lo), .time_hi(time_hi),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .stamp_hold(stamp_hold)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint now_l();
    return longint'(time_hi) * LIM + longint'(time_lo);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (pin_out == 1'b0 && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  // one run: program, find the first rise, then time two half-periods
  task automatic run_vec(input int h, input int delta, input int ie, input bit align);
    longint s, lr;
    int n;
    int he;
    he = (h == 0) ? 1 : h;
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd3);
    wr(3'd5, 32'd1);
    s = now_l() + delta;
    if (align) s = (longint'(time_hi) + 2) * LIM;
    wr(3'd1, h);
    wr(3'd2, 32'(s % LIM));
    wr(3'd3, 32'(s / LIM));
    wr(3'd0, 32'h7 | (ie << 3));
    if (delta < 0) begin
      chk(pin_out == 1'b0, "R3 low after arming write", pin_out, 0);
      @(negedge clk);
      chk(pin_out == 1'b1, "R3 past start rises next cycle", pin_out, 1);
    end else begin
      wait_rise(n);
      lr = now_l();
      chk(lr == s + 1, "R2 first rise time", lr, s + 1);
      if (align) chk(time_lo == 1, "R2 rise just after second boundary", time_lo, 1);
    end
    chk(irq == ie[0], "R8 irq at rise", irq, ie);
    n = 0;
    do begin @(negedge clk); n++; end while (pin_out == 1'b1 && n < 100);
    chk(n == he, "R6 high phase length", n, he);
    chk(irq == ie[0], "R8 irq at fall", irq, ie);
    n = 0;
    do begin @(negedge clk); n++; end while (pin_out == 1'b0 && n < 100);
    chk(n == he, "R6 low phase length", n, he);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] hprev;
    repeat (4) @(negedge clk);
    // R10 and R1 reset state
    chk(pin_out == 0 && pin_oe == 0 && irq == 0 && stamp_hold == 0,
        "R10 outputs idle in reset", {pin_out, pin_oe, irq, stamp_hold}, 0);
    chk(time_lo == 0 && time_hi == 0, "R1 time zero in reset", now_l(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(time_lo == 1 && time_hi == 0, "R1 first count", now_l(), 1);

    // R1 rollover
    while (time_lo != LIM - 1) @(negedge clk);
    hprev = time_hi;
    @(negedge clk);
    chk(time_lo == 0 && time_hi == hprev + 1, "R1 wrap carries", now_l(), longint'(hprev + 1) * LIM);

    // table of vectors
    for (int i = 0; i < NV; i++) run_vec(T_HALF[i], T_DELTA[i], T_IRQ[i], 1'b0);

    // R2 start exactly on a second boundary, coinciding with rollover
    run_vec(3, 0, 1, 1'b1);

    // R4 stop while running
    wr(3'd0, 32'd0);
    chk(pin_out == 0 && irq == 0, "R4 stop immediate", pin_out, 0);
    n = 0;
    repeat (30) begin @(negedge clk); if (pin_out || irq) n++; end
    chk(n == 0, "R4 stays stopped", n, 0);

    // R5 incomplete arming: each of the three bits missing in turn
    for (int b = 0; b < 3; b++) begin
      wr(3'd1, 32'd2);
      wr(3'd2, 32'd0);
      wr(3'd3, 32'd0);
      wr(3'd0, 32'h7 & ~(32'd1 << b));
      n = 0;
      repeat (20) begin @(negedge clk); if (pin_out || irq) n++; end
      chk(n == 0, "R5 no edge without full arming", n, 0);
    end

    // R7 pin gating
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd60);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd7);
    wait_rise(n);
    chk(pin_out == 1, "R7 wave visible with full routing", pin_out, 1);
    wr(3'd4, 32'd1);
    chk(pin_out == 0 && pin_oe == 1, "R7 function bit clear", pin_out, 0);
    wr(3'd4, 32'd2);
    chk(pin_out == 0 && pin_oe == 0, "R7 direction bit clear", {pin_out, pin_oe}, 0);
    wr(3'd4, 32'd3);
    chk(pin_out == 1 && pin_oe == 1, "R7 restored", {pin_out, pin_oe}, 3);
    wr(3'd5, 32'd3);
    chk(pin_out == 0, "R7 other source selected", pin_out, 0);
    wr(3'd5, 32'd0);
    chk(pin_out == 0, "R7 routing disabled", pin_out, 0);
    wr(3'd5, 32'd1);
    chk(pin_out == 1, "R7 routing back on", pin_out, 1);

    // R9 stamp keep bit
    wr(3'd0, 32'h10);
    chk(stamp_hold == 1, "R9 keep bit set", stamp_hold, 1);
    chk(pin_out == 0, "R4 nonzero control write restarts", pin_out, 0);
    wr(3'd0, 32'd0);
    chk(stamp_hold == 0, "R9 keep bit clear", stamp_hold, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule